// File: doc/BRIEF.md
# Erase-Before-Write Flash Page Remapper

This controller sits between a host that reads and writes logical pages and a flash array organised as physical blocks of equal-sized pages. Flash only lets a page be programmed once between erases of its block. The controller hides that rule. It keeps a table from each logical block to a physical block, and one written flag per logical page. It also keeps a free flag and an erase counter for every physical block. From these it decides, for every host write, whether the page can be programmed where it sits or whether the whole block has to move.

A write to a page that has never been written in an already mapped block is programmed in place. A write to a logical block with no mapping takes a free block, erases it and programs the page. A write over a page that already holds data relocates the block. The controller erases a free block, programs the new data into it, and copies every other written page of the old block in ascending page order. The mapping then moves to the new block and the old block returns to the free pool. When a free block is needed, the one with the fewest erases is taken, and on a tie the one with the lowest index. The host sees one response per request. For a write, that response comes only after the last flash command of the sequence has finished.

At least one physical block more than the number of logical blocks is always present, so a relocation always finds a target. Erase is a long busy operation. The flash side therefore uses an issue/done handshake, and only one command is in flight at a time.

Top module: `page_remap_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `fl_op` is 0 (no command) and `resp_valid` is 0.
- R2: A read of a logical page that has never been written responds with all ones in `resp_rdata` and issues no flash command.
- R3: A write to a logical block with no mapping erases one free physical block and then programs the page there. The block chosen is the free block with the lowest erase count, and on equal counts the lowest index.
- R4: A write to a never-written page of a mapped logical block issues exactly one program command, to the mapped block, with no erase.
- R5: A write over a page that already holds data issues, in this order: an erase of a newly chosen free block (chosen as in R3), a program of the new data into it, then for each other written page in ascending page order a read from the old block followed by a program to the new block. Later reads return the new data and the copied data.
- R6: No program command targets a page that was programmed after the last erase of its block.
- R7: Only one flash command is outstanding at a time. `fl_op` is nonzero (1 = read, 2 = program, 3 = erase) for one cycle per command, and no other command is issued until `fl_done` has returned.
- R8: Each accepted request gets exactly one `resp_valid` pulse, one cycle long. For writes the pulse comes only after the last flash command has completed, and no new request is accepted before it.
- R9: A logical page number is logical block × pages per block + page offset. A read of a written page issues a read of the mapped physical block at the same offset and returns the data from `fl_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | LPW (7) | Logical page number |
| req_wdata | input | DATA_W (16) | Page data for writes |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W (16) | Read data returned with the response |
| fl_op | output | 2 | Flash command: 0 none, 1 read, 2 program, 3 erase |
| fl_block | output | BW (3) | Physical block of the command |
| fl_page | output | OFFW (5) | Page within the block |
| fl_wdata | output | DATA_W (16) | Program data |
| fl_done | input | 1 | Flash command finished (one-cycle pulse) |
| fl_rdata | input | DATA_W (16) | Read data, valid with `fl_done` |

## Verification
On every cycle the assertions check four things. Programs only land on erased pages. Only one flash command is ever in flight. Responses pair one-to-one with accepted requests, and a response never appears while a flash command is pending. Which block a free-block choice lands on, the exact order of the erase, program and copy commands, and the page contents seen after a move depend on the history of erase counts. Only the bench's scenarios show these, by comparing the logged command stream and the read-back data against expected values.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;

   typedef enum logic [1:0] {
      FOP_NONE  = 2'd0,
      FOP_READ  = 2'd1,
      FOP_PROG  = 2'd2,
      FOP_ERASE = 2'd3
   } fop_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD,
      S_ERASE,
      S_PROG,
      S_CPY_CHK,
      S_CPY_RD,
      S_CPY_PR,
      S_FIN,
      S_DONE
   } fpr_state_e;

endpackage

// File: rtl/fpr_wear_bank.sv
`timescale 1ns/1ps
// Per-block erase counters and free flags, one slice per physical block.
module fpr_wear_bank #(
   parameter int NUM_BLOCKS = 6,
   parameter int CNT_W      = 17,
   parameter bit SAT_COUNT  = 1'b1,
   localparam int BW        = $clog2(NUM_BLOCKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        erase_en,
   input  logic [BW-1:0]               erase_blk,
   input  logic                        rel_en,
   input  logic [BW-1:0]               rel_blk,
   output logic [NUM_BLOCKS-1:0]       free_vec,
   output logic [NUM_BLOCKS*CNT_W-1:0] cnt_flat
);

   for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
      logic [CNT_W-1:0] cnt_q;
      logic             hit_erase;
      logic             bump;

      assign hit_erase = erase_en && (erase_blk == BW'(g));

      if (SAT_COUNT) begin : g_sat
         assign bump = hit_erase && (cnt_q != {CNT_W{1'b1}});
      end else begin : g_wrap
         assign bump = hit_erase;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q       <= '0;
            free_vec[g] <= 1'b1;
         end else begin
            if (bump) cnt_q <= cnt_q + 1'b1;
            if (hit_erase) free_vec[g] <= 1'b0;
            else if (rel_en && (rel_blk == BW'(g))) free_vec[g] <= 1'b1;
         end
      end

      assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;
   end

endmodule

// File: rtl/fpr_free_pick.sv
`timescale 1ns/1ps
// Chooses the free block with the fewest erases; ties go to the lowest index.
module fpr_free_pick #(
   parameter int NUM_BLOCKS = 6,
   parameter int CNT_W      = 17,
   localparam int BW        = $clog2(NUM_BLOCKS)
) (
   input  logic [NUM_BLOCKS-1:0]       free_vec,
   input  logic [NUM_BLOCKS*CNT_W-1:0] cnt_flat,
   output logic [BW-1:0]               pick_blk
);

   logic             found;
   logic [CNT_W-1:0] best_cnt;

   always_comb begin
      found    = 1'b0;
      best_cnt = '1;
      pick_blk = '0;
      for (int i = 0; i < NUM_BLOCKS; i++) begin
         if (free_vec[i] && (!found || (cnt_flat[i*CNT_W +: CNT_W] < best_cnt))) begin
            found    = 1'b1;
            best_cnt = cnt_flat[i*CNT_W +: CNT_W];
            pick_blk = BW'(i);
         end
      end
   end

endmodule

// File: rtl/fpr_map_table.sv
`timescale 1ns/1ps
// Logical-block to physical-block map with per-page written flags.
module fpr_map_table #(
   parameter int LOG_BLOCKS = 4,
   parameter int NUM_BLOCKS = 6,
   parameter int PAGES      = 32,
   localparam int LBW       = $clog2(LOG_BLOCKS),
   localparam int BW        = $clog2(NUM_BLOCKS),
   localparam int OFFW      = $clog2(PAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LBW-1:0]   rd_lblk,
   output logic             rd_mapped,
   output logic [BW-1:0]    rd_pblk,
   output logic [PAGES-1:0] rd_valid,
   input  logic             map_we,
   input  logic [LBW-1:0]   wr_lblk,
   input  logic [BW-1:0]    wr_pblk,
   input  logic             set_en,
   input  logic [OFFW-1:0]  set_page
);

   logic             mapped_q [LOG_BLOCKS];
   logic [BW-1:0]    pblk_q   [LOG_BLOCKS];
   logic [PAGES-1:0] valid_q  [LOG_BLOCKS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LOG_BLOCKS; i++) begin
            mapped_q[i] <= 1'b0;
            pblk_q[i]   <= '0;
            valid_q[i]  <= '0;
         end
      end else begin
         if (map_we) begin
            mapped_q[wr_lblk] <= 1'b1;
            pblk_q[wr_lblk]   <= wr_pblk;
         end
         if (set_en) valid_q[wr_lblk][set_page] <= 1'b1;
      end
   end

   assign rd_mapped = mapped_q[rd_lblk];
   assign rd_pblk   = pblk_q[rd_lblk];
   assign rd_valid  = valid_q[rd_lblk];

endmodule

// File: rtl/page_remap_ctrl.sv
`timescale 1ns/1ps
module page_remap_ctrl
   import fpr_pkg::*;
#(
   parameter int NUM_BLOCKS = 6,
   parameter int LOG_BLOCKS = 4,
   parameter int PAGES      = 32,
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 17,
   parameter bit SAT_COUNT  = 1'b1,
   localparam int BW        = $clog2(NUM_BLOCKS),
   localparam int LBW       = $clog2(LOG_BLOCKS),
   localparam int OFFW      = $clog2(PAGES),
   localparam int LPW       = LBW + OFFW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [LPW-1:0]    req_page,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_rdata,
   output logic [1:0]        fl_op,
   output logic [BW-1:0]     fl_block,
   output logic [OFFW-1:0]   fl_page,
   output logic [DATA_W-1:0] fl_wdata,
   input  logic              fl_done,
   input  logic [DATA_W-1:0] fl_rdata
);

   if (PAGES < 32 || PAGES > 128 || (1 << OFFW) != PAGES) begin : g_bad_pages
      $error("PAGES must be a power of two from 32 to 128");
   end
   if (LOG_BLOCKS < 2 || (1 << LBW) != LOG_BLOCKS) begin : g_bad_lblk
      $error("LOG_BLOCKS must be a power of two, at least 2");
   end
   if (LOG_BLOCKS > NUM_BLOCKS - 1) begin : g_bad_spare
      $error("at least one spare physical block is required");
   end

   localparam logic [OFFW-1:0] LAST_PG = OFFW'(PAGES - 1);

   fpr_state_e        st;
   logic              sent;
   logic [LBW-1:0]    cur_lblk;
   logic [OFFW-1:0]   cur_off;
   logic [DATA_W-1:0] cur_wdata;
   logic [DATA_W-1:0] rdata_q;
   logic [BW-1:0]     tgt_blk;
   logic [BW-1:0]     old_blk;
   logic              is_reloc;
   logic [OFFW-1:0]   cpy_idx;

   logic [LBW-1:0]    req_lblk;
   logic [OFFW-1:0]   req_off;
   logic [LBW-1:0]    map_idx;
   logic              rd_mapped;
   logic [BW-1:0]     rd_pblk;
   logic [PAGES-1:0]  rd_valid;
   logic [NUM_BLOCKS-1:0]       free_vec;
   logic [NUM_BLOCKS*CNT_W-1:0] cnt_flat;
   logic [BW-1:0]     pick_blk;
   logic              cmd_fin;
   fop_e              cmd_op;

   assign req_lblk = req_page[LPW-1:OFFW];
   assign req_off  = req_page[OFFW-1:0];
   assign map_idx  = (st == S_IDLE) ? req_lblk : cur_lblk;
   assign cmd_fin  = sent && fl_done;

   fpr_map_table #(.LOG_BLOCKS(LOG_BLOCKS), .NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES)) u_map (
      .clk(clk), .rst_n(rst_n),
      .rd_lblk(map_idx), .rd_mapped(rd_mapped), .rd_pblk(rd_pblk), .rd_valid(rd_valid),
      .map_we(st == S_FIN), .wr_lblk(cur_lblk), .wr_pblk(tgt_blk),
      .set_en(st == S_PROG && cmd_fin), .set_page(cur_off)
   );

   fpr_wear_bank #(.NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W), .SAT_COUNT(SAT_COUNT)) u_wear (
      .clk(clk), .rst_n(rst_n),
      .erase_en(st == S_ERASE && cmd_fin), .erase_blk(tgt_blk),
      .rel_en(st == S_FIN && is_reloc), .rel_blk(old_blk),
      .free_vec(free_vec), .cnt_flat(cnt_flat)
   );

   fpr_free_pick #(.NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W)) u_pick (
      .free_vec(free_vec), .cnt_flat(cnt_flat), .pick_blk(pick_blk)
   );

   // Command decode; the op is shown only until the command has been issued.
   always_comb begin
      cmd_op   = FOP_NONE;
      fl_block = '0;
      fl_page  = '0;
      fl_wdata = '0;
      unique case (st)
         S_RD:     begin cmd_op = FOP_READ;  fl_block = tgt_blk; fl_page = cur_off; end
         S_ERASE:  begin cmd_op = FOP_ERASE; fl_block = tgt_blk; end
         S_PROG:   begin cmd_op = FOP_PROG;  fl_block = tgt_blk; fl_page = cur_off; fl_wdata = cur_wdata; end
         S_CPY_RD: begin cmd_op = FOP_READ;  fl_block = old_blk; fl_page = cpy_idx; end
         S_CPY_PR: begin cmd_op = FOP_PROG;  fl_block = tgt_blk; fl_page = cpy_idx; fl_wdata = rdata_q; end
         default:  ;
      endcase
   end

   assign fl_op      = sent ? FOP_NONE : cmd_op;
   assign req_ready  = (st == S_IDLE);
   assign resp_valid = (st == S_DONE);
   assign resp_rdata = rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sent <= 1'b0;
      end else if (fl_op != FOP_NONE) begin
         sent <= 1'b1;
      end else if (fl_done) begin
         sent <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cur_lblk  <= '0;
         cur_off   <= '0;
         cur_wdata <= '0;
         rdata_q   <= '0;
         tgt_blk   <= '0;
         old_blk   <= '0;
         is_reloc  <= 1'b0;
         cpy_idx   <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (req_valid) begin
               cur_lblk  <= req_lblk;
               cur_off   <= req_off;
               cur_wdata <= req_wdata;
               is_reloc  <= 1'b0;
               if (!req_write) begin
                  if (rd_mapped && rd_valid[req_off]) begin
                     tgt_blk <= rd_pblk;
                     st      <= S_RD;
                  end else begin
                     rdata_q <= '1;
                     st      <= S_DONE;
                  end
               end else if (rd_mapped && !rd_valid[req_off]) begin
                  tgt_blk <= rd_pblk;
                  st      <= S_PROG;
               end else begin
                  tgt_blk  <= pick_blk;
                  old_blk  <= rd_pblk;
                  is_reloc <= rd_mapped;
                  st       <= S_ERASE;
               end
            end
            S_RD: if (cmd_fin) begin
               rdata_q <= fl_rdata;
               st      <= S_DONE;
            end
            S_ERASE: if (cmd_fin) st <= S_PROG;
            S_PROG: if (cmd_fin) begin
               cpy_idx <= '0;
               st      <= is_reloc ? S_CPY_CHK : S_FIN;
            end
            S_CPY_CHK: begin
               if (rd_valid[cpy_idx] && (cpy_idx != cur_off)) st <= S_CPY_RD;
               else if (cpy_idx == LAST_PG) st <= S_FIN;
               else cpy_idx <= cpy_idx + 1'b1;
            end
            S_CPY_RD: if (cmd_fin) begin
               rdata_q <= fl_rdata;
               st      <= S_CPY_PR;
            end
            S_CPY_PR: if (cmd_fin) begin
               if (cpy_idx == LAST_PG) begin
                  st <= S_FIN;
               end else begin
                  cpy_idx <= cpy_idx + 1'b1;
                  st      <= S_CPY_CHK;
               end
            end
            S_FIN:   st <= S_DONE;
            S_DONE:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/page_remap_chk.sv
`timescale 1ns/1ps
module page_remap_chk #(
   parameter int NUM_BLOCKS = 6,
   parameter int PAGES      = 32,
   localparam int BW        = $clog2(NUM_BLOCKS),
   localparam int OFFW      = $clog2(PAGES)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            resp_valid,
   input logic [1:0]      fl_op,
   input logic [BW-1:0]   fl_block,
   input logic [OFFW-1:0] fl_page,
   input logic            fl_done
);

   logic             outst_q;
   logic             pend_q;
   logic [PAGES-1:0] prog_q [NUM_BLOCKS];
   logic             blk_ok;
   logic             hit;

   assign blk_ok = {1'b0, fl_block} < (BW+1)'(NUM_BLOCKS);
   assign hit    = blk_ok ? prog_q[fl_block][fl_page] : 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst_q <= 1'b0;
         pend_q  <= 1'b0;
         for (int b = 0; b < NUM_BLOCKS; b++) prog_q[b] <= '0;
      end else begin
         if (fl_op != 2'd0) outst_q <= 1'b1;
         else if (fl_done) outst_q <= 1'b0;
         if (req_valid && req_ready) pend_q <= 1'b1;
         else if (resp_valid) pend_q <= 1'b0;
         if (blk_ok && fl_op == 2'd3) prog_q[fl_block] <= '0;
         else if (blk_ok && fl_op == 2'd2) prog_q[fl_block][fl_page] <= 1'b1;
      end
   end

   // R6
   erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_op == 2'd2) |-> (blk_ok && !hit));

   // R7
   one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_op != 2'd0) |-> !outst_q);

   // R8
   ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (pend_q && !outst_q));

   // R8
   single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R8
   no_early_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> !pend_q);

endmodule

bind page_remap_ctrl page_remap_chk #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .resp_valid(resp_valid), .fl_op(fl_op), .fl_block(fl_block),
   .fl_page(fl_page), .fl_done(fl_done)
);

// File: tb/page_remap_ctrl_test.sv
`timescale 1ns/1ps
module page_remap_ctrl_test;

   localparam int NB = 6, LB = 4, PG = 32, DW = 16;
   localparam int BW = 3, OFFW = 5, LPW = 7;
   localparam int PAGE_LAT = 2, ERASE_LAT = 40;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [LPW-1:0] req_page = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, resp_valid;
   logic [DW-1:0] resp_rdata;
   logic [1:0]    fl_op;
   logic [BW-1:0] fl_block;
   logic [OFFW-1:0] fl_page;
   logic [DW-1:0] fl_wdata;
   logic          fl_done = 1'b0;
   logic [DW-1:0] fl_rdata = '0;

   page_remap_ctrl #(.NUM_BLOCKS(NB), .LOG_BLOCKS(LB), .PAGES(PG), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_page(req_page), .req_wdata(req_wdata), .req_ready(req_ready),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata), .fl_op(fl_op),
      .fl_block(fl_block), .fl_page(fl_page), .fl_wdata(fl_wdata),
      .fl_done(fl_done), .fl_rdata(fl_rdata)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Flash model: pages, programmed flags, command log.
   logic [DW-1:0] fmem  [NB][PG];
   logic          fprog [NB][PG];
   logic [9:0]    log_e [64];
   logic [9:0]    exp_e [64];
   int log_n = 0, exp_n = 0, busy = 0;
   logic [1:0]    m_op;
   logic [BW-1:0] m_blk;
   logic [OFFW-1:0] m_pg;
   logic [DW-1:0] m_wd;

   initial begin
      for (int b = 0; b < NB; b++)
         for (int p = 0; p < PG; p++) begin
            fmem[b][p]  = '1;
            fprog[b][p] = 1'b0;
         end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         busy    = 0;
         fl_done = 1'b0;
      end else begin
         if (fl_done) fl_done = 1'b0;
         if (busy > 0) begin
            busy--;
            if (busy == 0) begin
               if (m_op == 2'd1) fl_rdata = fmem[m_blk][m_pg];
               else if (m_op == 2'd2) begin
                  check("R6 program lands on an erased page", int'(fprog[m_blk][m_pg]), 0);
                  fmem[m_blk][m_pg]  = m_wd;
                  fprog[m_blk][m_pg] = 1'b1;
               end else begin
                  for (int p = 0; p < PG; p++) begin
                     fmem[m_blk][p]  = '1;
                     fprog[m_blk][p] = 1'b0;
                  end
               end
               fl_done = 1'b1;
            end
         end else if (fl_op != 2'd0) begin
            if (log_n < 64) log_e[log_n] = {fl_op, fl_block, fl_page};
            log_n++;
            m_op  = fl_op;
            m_blk = fl_block;
            m_pg  = fl_page;
            m_wd  = fl_wdata;
            busy  = (fl_op == 2'd3) ? ERASE_LAT : PAGE_LAT;
         end
      end
   end

   function automatic int lp(input int lb, input int off);
      return lb * PG + off;
   endfunction

   task automatic exp_clear();
      exp_n = 0;
   endtask

   task automatic exp_add(input int op, input int blk, input int pg);
      exp_e[exp_n] = {2'(op), 3'(blk), 5'(pg)};
      exp_n++;
   endtask

   task automatic cmp_log(input string tag);
      check({tag, " command count"}, log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++)
         check({tag, " command {op,block,page}"}, int'(log_e[i]), int'(exp_e[i]));
   endtask

   task automatic host(input bit wr, input int page, input int data, output int rdata);
      int t;
      log_n = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_page  = LPW'(page);
      req_wdata = DW'(data);
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!resp_valid && t < 3000 && !finished) begin
         @(negedge clk);
         t++;
      end
      check("R8 response pulse arrives", int'(resp_valid), 1);
      rdata = int'(resp_rdata);
      @(negedge clk);
      check("R8 response lasts one cycle", int'(resp_valid), 0);
   endtask

   task automatic do_write(input string tag, input int page, input int data);
      int d;
      host(1'b1, page, data, d);
      cmp_log(tag);
   endtask

   task automatic do_read(input string tag, input int page, input int exp_data);
      int d;
      host(1'b0, page, 0, d);
      check({tag, " read data"}, d, exp_data);
      cmp_log(tag);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", int'(req_ready), 1);
      check("R1 no command after reset", int'(fl_op), 0);
      check("R1 no response after reset", int'(resp_valid), 0);
   endtask

   task automatic t_blank_read();
      exp_clear();
      do_read("R2 unwritten page", lp(0, 5), 16'hFFFF);
   endtask

   task automatic t_first_alloc();
      exp_clear(); exp_add(3, 0, 0); exp_add(2, 0, 3);
      do_write("R3 fresh block, all counts equal", lp(0, 3), 16'hA001);
      exp_clear(); exp_add(3, 1, 0); exp_add(2, 1, 0);
      do_write("R3 second fresh block", lp(1, 0), 16'hB001);
   endtask

   task automatic t_in_place();
      exp_clear(); exp_add(2, 0, 7);
      do_write("R4 in-place program", lp(0, 7), 16'hA002);
      exp_clear(); exp_add(1, 0, 7);
      do_read("R9 read mapped page", lp(0, 7), 16'hA002);
   endtask

   task automatic t_relocate();
      exp_clear(); exp_add(3, 2, 0); exp_add(2, 2, 3); exp_add(1, 0, 7); exp_add(2, 2, 7);
      do_write("R5 overwrite moves block", lp(0, 3), 16'hA003);
      exp_clear(); exp_add(1, 2, 3);
      do_read("R5 new data after move", lp(0, 3), 16'hA003);
      exp_clear(); exp_add(1, 2, 7);
      do_read("R5 copied data after move", lp(0, 7), 16'hA002);
      exp_clear(); exp_add(3, 3, 0); exp_add(2, 3, 7); exp_add(1, 2, 3); exp_add(2, 3, 3);
      do_write("R5 overwrite higher page", lp(0, 7), 16'hA004);
   endtask

   task automatic t_wear_pick();
      exp_clear(); exp_add(3, 4, 0); exp_add(2, 4, 0);
      do_write("R3 lower count beats lower index", lp(1, 0), 16'hB002);
      exp_clear(); exp_add(3, 5, 0); exp_add(2, 5, 3); exp_add(1, 3, 7); exp_add(2, 5, 7);
      do_write("R3 least-erased block picked", lp(0, 3), 16'hA005);
      exp_clear(); exp_add(3, 0, 0); exp_add(2, 0, 0);
      do_write("R3 tie goes to lowest index", lp(1, 0), 16'hB003);
      exp_clear(); exp_add(1, 5, 3);
      do_read("R5 final page 3", lp(0, 3), 16'hA005);
      exp_clear(); exp_add(1, 5, 7);
      do_read("R5 final page 7", lp(0, 7), 16'hA004);
      exp_clear(); exp_add(1, 0, 0);
      do_read("R9 other logical block", lp(1, 0), 16'hB003);
      exp_clear();
      do_read("R2 unwritten page in untouched block", lp(2, 1), 16'hFFFF);
   endtask

   task automatic t_last_page();
      exp_clear(); exp_add(3, 1, 0); exp_add(2, 1, 31);
      do_write("R3 last page of last logical block", lp(3, 31), 16'hC001);
      exp_clear(); exp_add(2, 1, 0);
      do_write("R4 first page in place", lp(3, 0), 16'hC002);
      exp_clear(); exp_add(3, 2, 0); exp_add(2, 2, 31); exp_add(1, 1, 0); exp_add(2, 2, 0);
      do_write("R5 overwrite last page", lp(3, 31), 16'hC003);
      exp_clear(); exp_add(1, 2, 0);
      do_read("R5 copied first page", lp(3, 0), 16'hC002);
      exp_clear(); exp_add(1, 2, 31);
      do_read("R5 new last page", lp(3, 31), 16'hC003);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R8: actual no completion expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_blank_read();
      t_first_alloc();
      t_in_place();
      t_relocate();
      t_wear_pick();
      t_last_page();
      repeat (5) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule